// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command state machine of a byte-wide flash memory model. Software writes address/data pairs to it one strobe at a time. A program or erase starts only after a fixed unlock preamble. Three operations are recognised: a byte program, the erase of one sector, and the erase of the whole array. Once an operation is accepted, an internal counter holds the block busy for a configurable number of clock cycles. This stands in for the slow nonvolatile operation. The stored array changes when that interval ends.

While the block is busy, the write port is dead and reads return status instead of array contents. Bit 7 of a status read is a polling bit, and bit 6 changes value on every status read. Software can therefore spin on either bit to learn when the operation has finished.

The array is kept deliberately small. Each sector holds only a few cells. The sector number comes from the address bits above the 4 KB offset, and the cell within the sector comes from the lowest address bits.

Top module: `nvm_cmd_decoder`

## Requirements
- R1: After reset, busy is 0, rdata is 00h and every cell reads FFh.
- R2: The writes AAh at key address 5555h, then 55h at 2AAAh, then A0h at 5555h, followed by any fourth write, start a byte program at the fourth write's address with its data. Key addresses are compared on addr[14:0]. busy is 1 from the clock edge that takes the fourth write.
- R3: busy stays high for exactly BUSY_CYCLES clock cycles. The array change is visible to the first read made after busy falls.
- R4: Any write that does not match the next expected step of a sequence returns the decoder to idle, and no operation starts.
- R5: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address, erase to FFh every cell of the sector selected by addr[15:12] of that last write. Other sectors are unchanged.
- R6: The same five-write prefix followed by 10h at 5555h erases every cell to FFh. A final 10h at any other address starts nothing.
- R7: Every write made while busy is 1 is ignored, including a complete unlock sequence.
- R8: A read while busy returns status. Bit 7 is the complement of bit 7 of the data being programmed during a program, and 0 during an erase. Bits 5:0 read 0.
- R9: Status bit 6 reads 0 on the first status read after an operation starts, and it inverts on each further status read.
- R10: A program only clears bits: the cell becomes its old value ANDed with the written data.
- R11: The cell is selected by addr[15:12] and addr[1:0], and addr[11:2] do not affect the selection. rdata is loaded on the edge that samples rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while an accepted operation is in progress |

## Verification
The hardest case to reach is a complete, well-formed unlock sequence that lands entirely inside a busy interval. It must leave no trace, either in the array or in a second busy period. The bench starts a program and, before the timer expires, issues a whole second program sequence to an untouched cell. It then waits for busy to fall and checks that busy does not rise again and that the cell still reads FFh. The status toggle is checked by several back-to-back reads inside one busy interval.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;
  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] CODE_OPEN   = 8'hAA;
  localparam logic [7:0] CODE_CONF   = 8'h55;
  localparam logic [7:0] CODE_PGM    = 8'hA0;
  localparam logic [7:0] CODE_ERASE  = 8'h80;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_ALL    = 8'h10;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_OPEN1, SEQ_CONF1, SEQ_PGM_WAIT,
    SEQ_ERA_ARM, SEQ_OPEN2, SEQ_CONF2
  } seq_state_t;

  typedef enum logic [1:0] {OP_NONE, OP_PGM, OP_SECTOR, OP_ALL} op_kind_t;

  function automatic logic [7:0] program_merge(input logic [7:0] old_v,
                                               input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  function automatic logic [7:0] status_byte(input op_kind_t kind,
                                             input logic [7:0] tgt,
                                             input logic tog);
    logic poll;
    poll = (kind == OP_PGM) ? ~tgt[7] : 1'b0;
    return {poll, tog, 6'b0};
  endfunction
endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
  import nvm_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             busy_i,
  input  logic [KEY_W-1:0] key_addr,
  input  logic [7:0]       wdata,
  output logic             start_pgm,
  output logic             start_sector,
  output logic             start_all
);
  seq_state_t state_q, state_d;
  logic at_a, at_b, wr_ok;

  assign at_a  = (key_addr == KEY_ADDR_A);
  assign at_b  = (key_addr == KEY_ADDR_B);
  assign wr_ok = wr_en && !busy_i;

  always_comb begin
    state_d      = state_q;
    start_pgm    = 1'b0;
    start_sector = 1'b0;
    start_all    = 1'b0;
    if (wr_ok) begin
      state_d = SEQ_IDLE;
      unique case (state_q)
        SEQ_IDLE:     if (at_a && wdata == CODE_OPEN) state_d = SEQ_OPEN1;
        SEQ_OPEN1:    if (at_b && wdata == CODE_CONF) state_d = SEQ_CONF1;
        SEQ_CONF1: begin
          if (at_a && wdata == CODE_PGM)        state_d = SEQ_PGM_WAIT;
          else if (at_a && wdata == CODE_ERASE) state_d = SEQ_ERA_ARM;
        end
        SEQ_PGM_WAIT: start_pgm = 1'b1;
        SEQ_ERA_ARM:  if (at_a && wdata == CODE_OPEN) state_d = SEQ_OPEN2;
        SEQ_OPEN2:    if (at_b && wdata == CODE_CONF) state_d = SEQ_CONF2;
        SEQ_CONF2: begin
          if (wdata == CODE_SECTOR)             start_sector = 1'b1;
          else if (at_a && wdata == CODE_ALL)   start_all = 1'b1;
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;

  a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pgm, start_sector, start_all}));
  a_r7_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> state_q == SEQ_IDLE);
endmodule

// File: rtl/nvm_busy_timer.sv
module nvm_busy_timer #(
  parameter int BUSY_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end

  a_r3_falls_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  a_r3_holds_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> busy_o);
  a_r2_rises_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array
  import nvm_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int CELL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgm_en,
  input  logic             sector_en,
  input  logic             all_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int NCELLS = 1 << IDX_W;
  localparam int SECT_W = IDX_W - CELL_W;

  logic [7:0] mem [NCELLS];
  logic [7:0] old_at_wr;
  logic [NCELLS-1:0] cell_is_ff;

  assign rd_data   = mem[rd_idx];
  assign old_at_wr = mem[wr_idx];

  for (genvar i = 0; i < NCELLS; i++) begin : g_ff
    assign cell_is_ff[i] = (mem[i] == 8'hFF);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCELLS; i++) mem[i] <= 8'hFF;
    end else begin
      if (pgm_en) mem[wr_idx] <= program_merge(old_at_wr, wr_data);
      for (int i = 0; i < NCELLS; i++) begin
        if (all_en || (sector_en && SECT_W'(i >> CELL_W) == wr_idx[IDX_W-1:CELL_W]))
          mem[i] <= 8'hFF;
      end
    end

  a_r10_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> (mem[$past(wr_idx)] & ~$past(old_at_wr)) == 8'h00);
  a_r6_all_erased: assert property (@(posedge clk) disable iff (!rst_n)
    all_en |=> &cell_is_ff);
endmodule

// File: rtl/nvm_cmd_decoder.sv
module nvm_cmd_decoder
  import nvm_cmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SECT_OFF_W  = 12,
  parameter int CELL_W      = 2,
  parameter int BUSY_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int SECT_W = ADDR_W - SECT_OFF_W;
  localparam int IDX_W  = SECT_W + CELL_W;

  function automatic logic [IDX_W-1:0] cell_index(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECT_OFF_W], a[CELL_W-1:0]};
  endfunction

  logic start_pgm, start_sector, start_all, any_start, op_done;
  op_kind_t op_kind_q;
  logic [IDX_W-1:0] op_idx_q;
  logic [7:0] op_data_q, arr_rd;
  logic tog_q;

  assign any_start = start_pgm || start_sector || start_all;

  nvm_unlock_seq u_seq (
    .clk, .rst_n, .wr_en, .busy_i(busy),
    .key_addr(addr[KEY_W-1:0]), .wdata,
    .start_pgm, .start_sector, .start_all
  );

  nvm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk, .rst_n, .start_i(any_start), .busy_o(busy), .done_o(op_done)
  );

  nvm_cell_array #(.IDX_W(IDX_W), .CELL_W(CELL_W)) u_array (
    .clk, .rst_n,
    .pgm_en(op_done && op_kind_q == OP_PGM),
    .sector_en(op_done && op_kind_q == OP_SECTOR),
    .all_en(op_done && op_kind_q == OP_ALL),
    .wr_idx(op_idx_q), .wr_data(op_data_q),
    .rd_idx(cell_index(addr)), .rd_data(arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      op_kind_q <= OP_NONE;
      op_idx_q  <= '0;
      op_data_q <= '0;
    end else if (any_start) begin
      op_kind_q <= start_pgm ? OP_PGM : (start_sector ? OP_SECTOR : OP_ALL);
      op_idx_q  <= cell_index(addr);
      op_data_q <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata <= 8'h00;
      tog_q <= 1'b0;
    end else begin
      if (any_start) tog_q <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rdata <= status_byte(op_kind_q, op_data_q, tog_q);
          tog_q <= ~tog_q;
        end else begin
          rdata <= arr_rd;
        end
      end
    end

  a_r8_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && busy && op_kind_q != OP_PGM |=> rdata[7] == 1'b0);
  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && busy |=> rdata[5:0] == 6'b0);
  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tb_nvm_cmd_decoder.sv
module tb_nvm_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 12;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic busy;
  int checks = 0, failures = 0;

  nvm_cmd_decoder #(.BUSY_CYCLES(BUSY)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic prog(logic [15:0] a, logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_prefix();
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy", {7'b0, busy}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rd(16'h7003, d); check("R1 cell", d, 8'hFF);
  endtask

  task automatic t_program_timing();
    logic [7:0] d; int n = 0;
    prog(16'h1001, 8'h3C);
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R2 R3 busy length", 8'(n), 8'(BUSY));
    rd(16'h1001, d); check("R2 programmed", d, 8'h3C);
    rd(16'h1FF5, d); check("R11 alias addr[11:2]", d, 8'h3C);
    rd(16'h1002, d); check("R11 neighbour", d, 8'hFF);
  endtask

  task automatic t_status();
    logic [7:0] d;
    prog(16'h2000, 8'h00);
    rd(16'h0000, d); check("R8 pgm poll", d, 8'h80);
    rd(16'h0000, d); check("R9 toggle 2nd", d, 8'hC0);
    rd(16'h0000, d); check("R9 toggle 3rd", d, 8'h80);
    @(negedge clk);
    check("R11 rdata holds", rdata, 8'h80);
    wait_idle();
    rd(16'h2000, d); check("R8 true data after", d, 8'h00);
  endtask

  task automatic t_and();
    logic [7:0] d;
    prog(16'h1001, 8'hF0); wait_idle();
    rd(16'h1001, d); check("R10 and merge", d, 8'h30);
  endtask

  task automatic t_ignore_busy();
    logic [7:0] d;
    prog(16'h3000, 8'h55);
    prog(16'h4000, 8'h00);
    wait_idle();
    repeat (BUSY + 4) @(negedge clk);
    check("R7 no second busy", {7'b0, busy}, 8'h00);
    rd(16'h4000, d); check("R7 cell untouched", d, 8'hFF);
    rd(16'h3000, d); check("R7 first op done", d, 8'h55);
  endtask

  task automatic t_bad_seq();
    logic [7:0] d;
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h4001, 8'h00);
    @(negedge clk); check("R4 no busy", {7'b0, busy}, 8'h00);
    rd(16'h4001, d); check("R4 cell", d, 8'hFF);
    erase_prefix(); wr(16'h1234, 8'h10);
    @(negedge clk); check("R6 wrong addr no start", {7'b0, busy}, 8'h00);
  endtask

  task automatic t_sector();
    logic [7:0] d;
    erase_prefix(); wr(16'h1ABC, 8'h30);
    rd(16'h0000, d); check("R8 erase poll", d, 8'h00);
    wait_idle();
    rd(16'h1001, d); check("R5 sector cell", d, 8'hFF);
    rd(16'h2000, d); check("R5 other sector", d, 8'h00);
    rd(16'h3000, d); check("R5 other sector b", d, 8'h55);
  endtask

  task automatic t_chip();
    logic [7:0] d;
    erase_prefix(); wr(16'h5555, 8'h10);
    @(negedge clk); check("R6 busy", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(16'h2000, d); check("R6 erased a", d, 8'hFF);
    rd(16'h3000, d); check("R6 erased b", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_program_timing(); t_status(); t_and();
    t_ignore_busy(); t_bad_seq(); t_sector(); t_chip();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule